// File: doc/BRIEF.md
# Write-Only Two-Wire Byte Streamer

This block sends a run of bytes over a two-wire SCL/SDA link as a master that only writes. It sends no address byte, leaves no acknowledge slot and never samples the data line. A single-cycle launch pulse starts a transfer. With the pulse come a 7-bit byte count and a 6-bit divider setting, and the block captures both at that moment. It then frames the payload with a start condition and a stop condition.

The payload comes from an external byte buffer. The block reads it through a read-enable/read-address port and gets the data back through a read-data input with one cycle of latency. The data must stay held while the enable is low, which is how a synchronous block RAM behaves. Each byte is fetched well before its first bit is needed.

A status output is high while the block is idle and low while a transfer is running. Taking the enable input low aborts any transfer at once and parks both lines high.

Top module: `pi2c_write_master`

## Requirements
- R1: After reset, and whenever no transfer is running, `scl`, `sda` and `idle` are 1 and `rd_en` is 0.
- R2: A `start` pulse sampled at a clock edge launches a transfer when all three hold: the block is idle, `enable` is high and `byte_count` is not 0. From that edge `sda` is 0, `scl` stays 1 and `idle` is 0. `scl` falls H-1 cycles later, where H = 2 * max(`clk_div`, 1).
- R3: A `clk_div` value of 0 produces exactly the timing of a value of 1, so H = 2.
- R4: Each data bit has two phases: `scl` is low for H cycles, then high for H cycles. `sda` takes the new bit one cycle after `scl` falls and stays stable while `scl` is high.
- R5: Bytes go out most significant bit first, with no acknowledge slot between bytes. They are read from buffer addresses 0 up to count-1 in ascending order, one `rd_en` pulse per byte with the address on `rd_addr`. `rd_data` is expected one cycle after the pulse and held until the next pulse.
- R6: After the last bit of the last byte, `scl` is low for H cycles with `sda` driven to 0 one cycle after the fall. `scl` then rises and stays high for H-1 cycles with `sda` at 0. `sda` and `idle` then rise together.
- R7: A `start` pulse while a transfer is running has no effect on the lines or on the fetch sequence.
- R8: A `start` pulse with `byte_count` equal to 0 is ignored: `idle` stays 1 and no fetch is issued.
- R9: While `enable` is low the block ignores `start`. Taking `enable` low during a transfer aborts it, so that at the next edge `scl`, `sda` and `idle` are 1 and `rd_en` is 0.
- R10: `byte_count` and `clk_div` are captured at launch. Changing them during a transfer changes neither its timing nor its length.
- R11: A count of 127 sends all 127 bytes in one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low aborts and parks the lines |
| start | input | 1 | One-cycle launch request |
| byte_count | input | 7 | Number of bytes to send, captured at launch |
| clk_div | input | 6 | Divider setting; half bit period H = 2*max(clk_div,1) |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | 7 | Buffer read address |
| rd_data | input | 8 | Buffer read data, valid one cycle after rd_en |
| scl | output | 1 | Serial clock line level |
| sda | output | 1 | Serial data line level |
| idle | output | 1 | 1 when idle, 0 while a transfer runs |

## Verification
Every state of the sequencer shows directly on the registered `scl`, `sda` and `idle` outputs. A wrong phase, a mis-loaded timer or a bad bit index therefore shows as a level or edge that lands off its expected cycle, and the bench catches it on the first clock where it diverges. A wrong byte index shows either as a wrong `rd_addr` on the next fetch strobe or as wrong data bits within one byte time. A stop that comes early or late, or a lost abort, shows in `idle` within a single cycle.

// File: rtl/pi2c_pkg.sv
package pi2c_pkg;

  // Sequencer phases of a transfer.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_STOP_LOW,
    PH_STOP_HIGH
  } phase_e;

endpackage

// File: rtl/pi2c_phase_timer.sv
// Down-counter that times each phase; load wins over counting.
module pi2c_phase_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pi2c_byte_feeder.sv
// Fetches bytes from the external buffer and presents them bit by bit.
module pi2c_byte_feeder #(
  parameter int CNT_W  = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              launch,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              load_byte,
  input  logic              shift_bit,
  input  logic              advance,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_en,
  output logic [CNT_W-1:0]  rd_addr,
  output logic              tx_bit,
  output logic              first_bit,
  output logic              last_bit,
  output logic              last_byte
);

  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  byte_idx;
  logic [CNT_W-1:0]  next_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] shreg;

  assign next_idx = byte_idx + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      byte_idx <= '0;
      bit_idx  <= TOP_BIT;
      shreg    <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_en <= 1'b0;
      if (abort) begin
        byte_idx <= '0;
        bit_idx  <= TOP_BIT;
      end else if (launch) begin
        count_q  <= count_in;
        byte_idx <= '0;
        bit_idx  <= TOP_BIT;
        rd_en    <= 1'b1;
        rd_addr  <= '0;
      end else begin
        if (load_byte) begin
          shreg <= rd_data << 1;
          // prefetch the following byte while this one shifts out
          if (next_idx != count_q) begin
            rd_en   <= 1'b1;
            rd_addr <= next_idx;
          end
        end else if (shift_bit) begin
          shreg <= shreg << 1;
        end
        if (advance) begin
          if (bit_idx == '0) begin
            bit_idx  <= TOP_BIT;
            byte_idx <= next_idx;
          end else begin
            bit_idx <= bit_idx - BIT_W'(1);
          end
        end
      end
    end
  end

  assign tx_bit    = load_byte ? rd_data[BYTE_W-1] : shreg[BYTE_W-1];
  assign first_bit = (bit_idx == TOP_BIT);
  assign last_bit  = (bit_idx == '0);
  assign last_byte = (next_idx == count_q);

endmodule

// File: rtl/pi2c_seq_ctrl.sv
// Phase sequencer: owns the registered line levels and the idle flag.
module pi2c_seq_ctrl
  import pi2c_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int DIV_W = 6,
  localparam int TW   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [TW-1:0]    t_cnt,
  input  logic             t_done,
  input  logic             tx_bit,
  input  logic             first_bit,
  input  logic             last_bit,
  input  logic             last_byte,
  output logic             t_load,
  output logic [TW-1:0]    t_val,
  output logic             launch,
  output logic             abort,
  output logic             load_byte,
  output logic             shift_bit,
  output logic             advance,
  output logic             scl,
  output logic             sda,
  output logic             idle
);

  phase_e           st, st_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] eff_in;
  logic [TW-1:0]    half_in, half_q;
  logic             scl_n, sda_n, idle_n;
  logic             low_first;

  assign eff_in    = (clk_div == '0) ? DIV_W'(1) : clk_div;
  assign half_in   = {eff_in, 1'b0};
  assign half_q    = {div_q, 1'b0};
  assign low_first = (t_cnt == half_q - TW'(1));

  always_comb begin
    st_n      = st;
    div_n     = div_q;
    scl_n     = scl;
    sda_n     = sda;
    idle_n    = idle;
    t_load    = 1'b0;
    t_val     = '0;
    launch    = 1'b0;
    abort     = 1'b0;
    load_byte = 1'b0;
    shift_bit = 1'b0;
    advance   = 1'b0;
    if (!enable) begin
      abort  = (st != PH_IDLE);
      st_n   = PH_IDLE;
      scl_n  = 1'b1;
      sda_n  = 1'b1;
      idle_n = 1'b1;
    end else begin
      case (st)
        PH_IDLE: begin
          if (start && byte_count != '0) begin
            st_n   = PH_START;
            sda_n  = 1'b0;
            idle_n = 1'b0;
            launch = 1'b1;
            div_n  = eff_in;
            t_load = 1'b1;
            t_val  = half_in - TW'(2);
          end
        end
        PH_START: begin
          if (t_done) begin
            st_n   = PH_LOW;
            scl_n  = 1'b0;
            t_load = 1'b1;
            t_val  = half_q - TW'(1);
          end
        end
        PH_LOW: begin
          if (low_first) begin
            if (first_bit) load_byte = 1'b1;
            else           shift_bit = 1'b1;
            sda_n = tx_bit;
          end
          if (t_done) begin
            st_n   = PH_HIGH;
            scl_n  = 1'b1;
            t_load = 1'b1;
            t_val  = half_q - TW'(1);
          end
        end
        PH_HIGH: begin
          if (t_done) begin
            advance = 1'b1;
            scl_n   = 1'b0;
            t_load  = 1'b1;
            t_val   = half_q - TW'(1);
            st_n    = (last_bit && last_byte) ? PH_STOP_LOW : PH_LOW;
          end
        end
        PH_STOP_LOW: begin
          if (low_first) sda_n = 1'b0;
          if (t_done) begin
            st_n   = PH_STOP_HIGH;
            scl_n  = 1'b1;
            t_load = 1'b1;
            t_val  = half_q - TW'(2);
          end
        end
        PH_STOP_HIGH: begin
          if (t_done) begin
            st_n   = PH_IDLE;
            sda_n  = 1'b1;
            idle_n = 1'b1;
          end
        end
        default: begin
          st_n   = PH_IDLE;
          scl_n  = 1'b1;
          sda_n  = 1'b1;
          idle_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_IDLE;
      div_q <= DIV_W'(1);
      scl   <= 1'b1;
      sda   <= 1'b1;
      idle  <= 1'b1;
    end else begin
      st    <= st_n;
      div_q <= div_n;
      scl   <= scl_n;
      sda   <= sda_n;
      idle  <= idle_n;
    end
  end

endmodule

// File: rtl/pi2c_write_master.sv
module pi2c_write_master #(
  parameter int CNT_W  = 7,
  parameter int DIV_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              rd_en,
  output logic [CNT_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              scl,
  output logic              sda,
  output logic              idle
);

  localparam int TW = DIV_W + 1;

  logic          t_load, t_done;
  logic [TW-1:0] t_val, t_cnt;
  logic          launch, abort, load_byte, shift_bit, advance;
  logic          tx_bit, first_bit, last_bit, last_byte;

  pi2c_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .cnt      (t_cnt),
    .done     (t_done)
  );

  pi2c_byte_feeder #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_feeder (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .launch    (launch),
    .count_in  (byte_count),
    .load_byte (load_byte),
    .shift_bit (shift_bit),
    .advance   (advance),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .tx_bit    (tx_bit),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .last_byte (last_byte)
  );

  pi2c_seq_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start      (start),
    .byte_count (byte_count),
    .clk_div    (clk_div),
    .t_cnt      (t_cnt),
    .t_done     (t_done),
    .tx_bit     (tx_bit),
    .first_bit  (first_bit),
    .last_bit   (last_bit),
    .last_byte  (last_byte),
    .t_load     (t_load),
    .t_val      (t_val),
    .launch     (launch),
    .abort      (abort),
    .load_byte  (load_byte),
    .shift_bit  (shift_bit),
    .advance    (advance),
    .scl        (scl),
    .sda        (sda),
    .idle       (idle)
  );

endmodule

// File: rtl/pi2c_write_master_chk.sv
module pi2c_write_master_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             rd_en,
  input logic             scl,
  input logic             sda,
  input logic             idle
);

  // R1
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> (scl && sda && !rd_en));

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && enable && start && byte_count != '0) |=> (!idle && !sda && scl));

  // R4
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (scl && $past(scl) && (sda != $past(sda))) |->
      (($fell(sda) && $fell(idle)) || ($rose(sda) && $rose(idle))));

  // R8
  zero_count_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && start && byte_count == '0) |=> idle);

  // R9
  disable_parks_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (idle && scl && sda && !rd_en));

endmodule

bind pi2c_write_master pi2c_write_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .start      (start),
  .byte_count (byte_count),
  .rd_en      (rd_en),
  .scl        (scl),
  .sda        (sda),
  .idle       (idle)
);

// File: tb/pi2c_write_master_test.sv
module pi2c_write_master_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       start = 1'b0;
  logic [6:0] byte_count = '0;
  logic [5:0] clk_div = '0;
  logic       rd_en;
  logic [6:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic       scl, sda, idle;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  logic [7:0] mem [128];
  bit exp_scl[$];
  bit exp_sda[$];
  bit exp_idle[$];
  int exp_addr[$];

  always #10 clk = ~clk;

  pi2c_write_master uut (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .byte_count(byte_count), .clk_div(clk_div),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .scl(scl), .sda(sda), .idle(idle)
  );

  // synchronous buffer model: one cycle latency, holds when not read
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void put(bit c, bit d, bit i, int n);
    for (int k = 0; k < n; k++) begin
      exp_scl.push_back(c);
      exp_sda.push_back(d);
      exp_idle.push_back(i);
    end
  endfunction

  function automatic void clear_model();
    exp_scl.delete();
    exp_sda.delete();
    exp_idle.delete();
    exp_addr.delete();
  endfunction

  // waveform built from the requirements (R2..R6)
  function automatic void build(int cnt, int dv);
    int  h;
    bit  prev;
    h = ((dv == 0) ? 1 : dv) * 2;
    prev = 1'b0;
    put(1, 0, 0, h - 1);
    for (int b = 0; b < cnt; b++) begin
      exp_addr.push_back(b);
      for (int i = 7; i >= 0; i--) begin
        bit v;
        v = mem[b][i];
        put(0, prev, 0, 1);
        put(0, v, 0, h - 1);
        put(1, v, 0, h);
        prev = v;
      end
    end
    put(0, prev, 0, 1);
    put(0, 0, 0, h - 1);
    put(1, 0, 0, h - 1);
    put(1, 1, 1, 1);
  endfunction

  // reference model decisions at the active edge
  always @(posedge clk) begin
    if (rst || !enable) clear_model();
    else if (start && exp_scl.size() == 0 && byte_count != 0)
      build(int'(byte_count), int'(clk_div));
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit es, ed, ei;
      if (exp_scl.size() != 0) begin
        es = exp_scl.pop_front();
        ed = exp_sda.pop_front();
        ei = exp_idle.pop_front();
      end else begin
        es = 1; ed = 1; ei = 1;
      end
      check({scl, sda, idle} == {es, ed, ei}, "lines {scl,sda,idle}",
            int'({scl, sda, idle}), int'({es, ed, ei}));
      if (rd_en) begin
        // R5 fetch order
        if (exp_addr.size() == 0) check(0, "R5 unexpected rd_en addr", int'(rd_addr), -1);
        else begin
          int ea;
          ea = exp_addr.pop_front();
          check(int'(rd_addr) == ea, "R5 rd_addr", int'(rd_addr), ea);
        end
      end
    end
  end

  task automatic launch(int cnt, int dv);
    @(negedge clk);
    byte_count = 7'(cnt);
    clk_div = 6'(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!idle);
    repeat (3) @(negedge clk);
    check(exp_addr.size() == 0, "R5 all bytes fetched", exp_addr.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 91) ^ (i << 3));
    mem[0] = 8'hA5;
    mem[1] = 8'h3C;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog %s actual=hung expected=done", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    check(scl && sda && idle && !rd_en, "R1 reset state", int'({scl, sda, idle, rd_en}), 4'b1110);
    enable = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R2 R4 R5 R6";
    launch(2, 1);
    wait_idle();

    tag = "R3";
    launch(1, 0);
    wait_idle();

    tag = "R7 R10";
    launch(3, 5);
    repeat (30) @(negedge clk);
    byte_count = 7'd9;
    clk_div = 6'd2;
    repeat (70) @(negedge clk);
    start = 1'b1;            // R7: busy start must be ignored
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    tag = "R8";
    launch(0, 3);
    check(idle == 1'b1, "R8 idle after zero count", int'(idle), 1);
    check(rd_en == 1'b0, "R8 no fetch", int'(rd_en), 0);
    repeat (4) @(negedge clk);

    tag = "R11";
    launch(127, 1);
    wait_idle();

    tag = "R9";
    launch(4, 3);
    repeat (50) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl && sda && idle && !rd_en, "R9 abort parks lines",
          int'({scl, sda, idle, rd_en}), 4'b1110);
    byte_count = 7'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(idle == 1'b1, "R9 start ignored when disabled", int'(idle), 1);
    enable = 1'b1;
    repeat (3) @(negedge clk);

    tag = "R4 R6";
    launch(2, 63);
    wait_idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule